// File: doc/BRIEF.md
# Calorimeter Space-Time Sum Trigger

This block builds fast trigger decisions from a rectangular grid of 12-bit energy samples. A full grid arrives on every clock edge at the sampling rate. For each position where a 4x4 square of cells fits inside the grid, the block adds the sixteen cell values. It then adds each of these spatial sums over the four most recent sample sets, which gives a space-time energy figure for every window.

The first-level decision (`l0Trig`) fires when some window's space-time sum is at its local maximum in time and lies above a programmable low threshold. This keeps each trigger aligned to the sample clock and limits it to a single cycle per pulse. Only the windows that raise this first-level decision are compared against three higher graded thresholds. These comparisons drive the second-level outputs `l1Low`, `l1Mid` and `l1High`.

Each second-level decision also writes a record into a small circular hit store. The record holds the winning window, its threshold mask and a cycle timestamp. The hit store can be read back through a registered address/data port. Decisions leave the block a fixed three cycles after the sample that confirms the peak, which is far inside a 5 us budget.

Top module: `stt_trigger`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge), `l0Trig`, `l1Low`, `l1Mid`, `l1High` are 0, and every hit-store entry reads back as 0.
- R2: Cell (r,c) sits at `sampleGrid[(r*COLS+c)*12 +: 12]`. Window w = r0*(COLS-3)+c0 covers rows r0..r0+3 and columns c0..c0+3. Windows exist only where the 4x4 square fits, which gives 55 windows with the default 8x14 grid.
- R3: The space-time sum T(n,w) of window w is the sum of its spatial sums over sample sets n, n-1, n-2 and n-3. Sets before the first one after reset count as zero.
- R4: Window w peaks at set n when T(n,w) >= T(n-1,w) and T(n,w) > T(n+1,w). On a flat top, therefore, only the last equal value counts as the peak.
- R5: A peak counts for the first level only if T(n,w) > `thrL0`, strictly. A sum equal to the threshold does not fire.
- R6: `l0Trig` is the OR over all windows of a qualifying peak at set n. It is valid after the third rising edge after the edge that captures set n. It stays high for exactly that one cycle.
- R7: In the same cycle as `l0Trig`, `l1Low`, `l1Mid` and `l1High` each give the OR, over the windows that raised `l0Trig`, of T > `thrL1Low`, T > `thrL1Mid` and T > `thrL1High` respectively.
- R8: No second-level output asserts in a cycle in which `l0Trig` is low, even when a second-level threshold is below `thrL0`.
- R9: Each cycle in which any second-level output is high writes exactly one hit-store entry. Entries go to addresses 0, 1, 2, ... and wrap after the last of the 16 entries.
- R10: An entry holds bits [5:0], the index of the lowest-numbered window that raised `l0Trig` and exceeded at least one second-level threshold, and bits [8:6], that window's mask (bit 6 low, bit 7 mid, bit 8 high). Bits [24:9] hold the 16-bit count of rising edges since reset was released, with the first edge counted as 0, taken at the edge where the entry is written.
- R11: `rdData` shows the entry at `rdAddr` one rising edge after `rdAddr` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one grid per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sampleGrid | input | 1344 | All cells of one sample set, 12 bits each, row-major |
| thrL0 | input | 18 | First-level threshold |
| thrL1Low | input | 18 | Second-level low threshold |
| thrL1Mid | input | 18 | Second-level mid threshold |
| thrL1High | input | 18 | Second-level high threshold |
| rdAddr | input | 4 | Hit-store read address |
| l0Trig | output | 1 | First-level decision |
| l1Low | output | 1 | Second-level low decision |
| l1Mid | output | 1 | Second-level mid decision |
| l1High | output | 1 | Second-level high decision |
| rdData | output | 25 | Hit-store entry {stamp, mask, window} |

## Verification
A wrong value in the spatial adders or in the four-deep history shifts a window's space-time sum. At the ports this shows up as a missing, extra or misplaced `l0Trig` pulse, exactly three edges after the sample set concerned. It can also show as a second-level bit that disagrees with the graded thresholds in that same cycle. A fault in the write pointer, the timestamp counter or the winner selection does not show on the decision pins. It becomes visible only when the hit store is read back, one edge after the address is applied. Every flat-top, threshold-equality and grid-corner pulse is therefore followed by a full readback of all sixteen entries against a model of the store.

// File: rtl/stt_pkg.sv
package stt_pkg;

  // strobes issued by the control part to the datapath each cycle
  typedef struct packed {
    logic hitWrite;
  } stt_strobe_t;

  // number of window origins along one axis of length n
  function automatic int winSpan(input int n, input int span);
    return n - span + 1;
  endfunction

endpackage

// File: rtl/stt_control.sv
module stt_control #(
  parameter int HIT_DEPTH = 16,
  parameter int TS_W      = 16,
  localparam int PTR_W    = $clog2(HIT_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                l1Any,
  output stt_pkg::stt_strobe_t strobe,
  output logic [PTR_W-1:0]    wrAddr,
  output logic [TS_W-1:0]     stamp
);

  logic [TS_W-1:0] cycCnt;

  assign strobe.hitWrite = l1Any;
  assign stamp           = cycCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt <= '0;
      wrAddr <= '0;
    end else begin
      cycCnt <= cycCnt + 1'b1;
      if (l1Any) begin
        wrAddr <= (wrAddr == PTR_W'(HIT_DEPTH - 1)) ? '0 : wrAddr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stt_datapath.sv
module stt_datapath #(
  parameter int ROWS      = 8,
  parameter int COLS      = 14,
  parameter int SAMPLE_W  = 12,
  parameter int SPAN      = 4,
  parameter int TDEPTH    = 4,
  parameter int HIT_DEPTH = 16,
  parameter int TS_W      = 16,
  localparam int WR       = stt_pkg::winSpan(ROWS, SPAN),
  localparam int WC       = stt_pkg::winSpan(COLS, SPAN),
  localparam int NWIN     = WR * WC,
  localparam int IDX_W    = $clog2(NWIN),
  localparam int SP_W     = SAMPLE_W + $clog2(SPAN * SPAN),
  localparam int T_W      = SP_W + $clog2(TDEPTH),
  localparam int PTR_W    = $clog2(HIT_DEPTH),
  localparam int ENT_W    = TS_W + 3 + IDX_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ROWS*COLS*SAMPLE_W-1:0] sampleGrid,
  input  logic [T_W-1:0]              thrL0,
  input  logic [T_W-1:0]              thrL1Low,
  input  logic [T_W-1:0]              thrL1Mid,
  input  logic [T_W-1:0]              thrL1High,
  input  stt_pkg::stt_strobe_t        strobe,
  input  logic [PTR_W-1:0]            wrAddr,
  input  logic [TS_W-1:0]             stamp,
  input  logic [PTR_W-1:0]            rdAddr,
  output logic                        l1Any,
  output logic                        l0Trig,
  output logic                        l1Low,
  output logic                        l1Mid,
  output logic                        l1High,
  output logic [ENT_W-1:0]            rdData
);

  logic [NWIN-1:0] peakVec, lowVec, midVec, highVec;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int R0 = w / WC;
    localparam int C0 = w % WC;

    logic [SP_W-1:0] spComb, spReg;
    logic [SP_W-1:0] hist [TDEPTH-1];
    logic [T_W-1:0]  tComb, tCur, tMid, tOld;

    // 4x4 spatial sum of the incoming sample set
    always_comb begin
      logic [SP_W-1:0] acc;
      acc = '0;
      for (int dr = 0; dr < SPAN; dr++) begin
        for (int dc = 0; dc < SPAN; dc++) begin
          acc = acc + SP_W'(sampleGrid[((R0 + dr) * COLS + C0 + dc) * SAMPLE_W +: SAMPLE_W]);
        end
      end
      spComb = acc;
    end

    // time sum over the newest spatial sum and the history
    always_comb begin
      logic [T_W-1:0] acc;
      acc = T_W'(spReg);
      for (int k = 0; k < TDEPTH - 1; k++) begin
        acc = acc + T_W'(hist[k]);
      end
      tComb = acc;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        spReg <= '0;
        for (int k = 0; k < TDEPTH - 1; k++) hist[k] <= '0;
        tCur <= '0;
        tMid <= '0;
        tOld <= '0;
      end else begin
        spReg   <= spComb;
        hist[0] <= spReg;
        for (int k = 1; k < TDEPTH - 1; k++) hist[k] <= hist[k-1];
        tCur <= tComb;
        tMid <= tCur;
        tOld <= tMid;
      end
    end

    // tMid is the candidate, tOld its predecessor, tCur its successor
    assign peakVec[w] = (tMid >= tOld) && (tMid > tCur) && (tMid > thrL0);
    assign lowVec[w]  = peakVec[w] && (tMid > thrL1Low);
    assign midVec[w]  = peakVec[w] && (tMid > thrL1Mid);
    assign highVec[w] = peakVec[w] && (tMid > thrL1High);
  end

  assign l1Any = (|lowVec) | (|midVec) | (|highVec);

  // lowest-numbered window with a graded hit wins the record
  logic [IDX_W-1:0] selIdx;
  logic [2:0]       selMask;

  always_comb begin
    selIdx  = '0;
    selMask = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (lowVec[w] | midVec[w] | highVec[w]) begin
        selIdx  = IDX_W'(w);
        selMask = {highVec[w], midVec[w], lowVec[w]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l0Trig <= 1'b0;
      l1Low  <= 1'b0;
      l1Mid  <= 1'b0;
      l1High <= 1'b0;
    end else begin
      l0Trig <= |peakVec;
      l1Low  <= |lowVec;
      l1Mid  <= |midVec;
      l1High <= |highVec;
    end
  end

  logic [ENT_W-1:0] hitMem [HIT_DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIT_DEPTH; i++) hitMem[i] <= '0;
      rdData <= '0;
    end else begin
      if (strobe.hitWrite) hitMem[wrAddr] <= {stamp, selMask, selIdx};
      rdData <= hitMem[rdAddr];
    end
  end

endmodule

// File: rtl/stt_trigger.sv
module stt_trigger #(
  parameter int ROWS      = 8,
  parameter int COLS      = 14,
  parameter int SAMPLE_W  = 12,
  parameter int SPAN      = 4,
  parameter int TDEPTH    = 4,
  parameter int HIT_DEPTH = 16,
  parameter int TS_W      = 16,
  localparam int NWIN     = stt_pkg::winSpan(ROWS, SPAN) * stt_pkg::winSpan(COLS, SPAN),
  localparam int IDX_W    = $clog2(NWIN),
  localparam int T_W      = SAMPLE_W + $clog2(SPAN * SPAN) + $clog2(TDEPTH),
  localparam int PTR_W    = $clog2(HIT_DEPTH),
  localparam int ENT_W    = TS_W + 3 + IDX_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ROWS*COLS*SAMPLE_W-1:0] sampleGrid,
  input  logic [T_W-1:0]                thrL0,
  input  logic [T_W-1:0]                thrL1Low,
  input  logic [T_W-1:0]                thrL1Mid,
  input  logic [T_W-1:0]                thrL1High,
  input  logic [PTR_W-1:0]              rdAddr,
  output logic                          l0Trig,
  output logic                          l1Low,
  output logic                          l1Mid,
  output logic                          l1High,
  output logic [ENT_W-1:0]              rdData
);

  stt_pkg::stt_strobe_t ctlStrobe;
  logic [PTR_W-1:0]     wrAddr;
  logic [TS_W-1:0]      stamp;
  logic                 l1Any;

  stt_control #(.HIT_DEPTH(HIT_DEPTH), .TS_W(TS_W)) u_ctl (
    .clk(clk), .rst(rst), .l1Any(l1Any),
    .strobe(ctlStrobe), .wrAddr(wrAddr), .stamp(stamp)
  );

  stt_datapath #(
    .ROWS(ROWS), .COLS(COLS), .SAMPLE_W(SAMPLE_W), .SPAN(SPAN),
    .TDEPTH(TDEPTH), .HIT_DEPTH(HIT_DEPTH), .TS_W(TS_W)
  ) u_dp (
    .clk(clk), .rst(rst), .sampleGrid(sampleGrid),
    .thrL0(thrL0), .thrL1Low(thrL1Low), .thrL1Mid(thrL1Mid), .thrL1High(thrL1High),
    .strobe(ctlStrobe), .wrAddr(wrAddr), .stamp(stamp), .rdAddr(rdAddr),
    .l1Any(l1Any), .l0Trig(l0Trig), .l1Low(l1Low), .l1Mid(l1Mid), .l1High(l1High),
    .rdData(rdData)
  );

endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             l0Trig,
  input logic             l1Low,
  input logic             l1Mid,
  input logic             l1High,
  input logic             hitWrite,
  input logic [PTR_W-1:0] wrAddr
);

  // R8: graded outputs only alongside the first-level decision
  a_r8_l1_needs_l0: assert property (@(posedge clk) disable iff (rst)
    (l1Low || l1Mid || l1High) |-> l0Trig);

  // R9: a write strobe is followed by a visible second-level decision
  a_r9_write_shows_l1: assert property (@(posedge clk) disable iff (rst)
    hitWrite |=> (l1Low || l1Mid || l1High));

  // R9: write address steps by one per write
  a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
    hitWrite |=> (wrAddr == PTR_W'($past(wrAddr) + 1'b1)));

  // R9: write address holds without a write
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !hitWrite |=> $stable(wrAddr));

  // R6: a write strobe also yields a first-level pulse
  a_r6_write_with_l0: assert property (@(posedge clk) disable iff (rst)
    hitWrite |=> l0Trig);

endmodule

bind stt_trigger stt_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .l0Trig(l0Trig), .l1Low(l1Low), .l1Mid(l1Mid),
  .l1High(l1High), .hitWrite(ctlStrobe.hitWrite), .wrAddr(wrAddr)
);

// File: tb/tb_stt_trigger.sv
`timescale 1ns/1ps
module tb_stt_trigger;

  localparam int ROWS = 8, COLS = 14, SW = 12;
  localparam int WC = COLS - 3, NWIN = (ROWS - 3) * WC;
  localparam int HD = 16, NMAX = 800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROWS*COLS*SW-1:0] sampleGrid = '0;
  logic [ROWS*COLS*SW-1:0] grid;
  logic [17:0] thrL0, thrL1Low, thrL1Mid, thrL1High;
  logic [3:0]  rdAddr = '0;
  logic        l0Trig, l1Low, l1Mid, l1High;
  logic [24:0] rdData;

  always #4 clk = ~clk;

  stt_trigger dut (
    .clk(clk), .rst(rst), .sampleGrid(sampleGrid), .thrL0(thrL0),
    .thrL1Low(thrL1Low), .thrL1Mid(thrL1Mid), .thrL1High(thrL1High),
    .rdAddr(rdAddr), .l0Trig(l0Trig), .l1Low(l1Low), .l1Mid(l1Mid),
    .l1High(l1High), .rdData(rdData)
  );

  int checks = 0, fails = 0;
  int n = 0, edgeNo = 0, wp = 0;
  int t0, tLo, tMi, tHi;
  int spH [NMAX][NWIN];
  logic [24:0] mdl [HD];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (set %0d)", tag, act, exp, n);
    end
  endtask

  function automatic int winSumOf(int w);
    int r0 = w / WC, c0 = w % WC, s = 0;
    for (int dr = 0; dr < 4; dr++)
      for (int dc = 0; dc < 4; dc++)
        s += int'(grid[((r0 + dr) * COLS + c0 + dc) * SW +: SW]);
    return s;
  endfunction

  function automatic int tAt(int j, int w);
    int s = 0;
    for (int k = j - 3; k <= j; k++) if (k >= 0) s += spH[k][w];
    return s;
  endfunction

  function automatic bit peakAt(int j, int w);
    int t = tAt(j, w);
    if (j < 0) return 1'b0;
    return (t >= tAt(j - 1, w)) && (t > tAt(j + 1, w)) && (t > t0);
  endfunction

  task automatic setThr(int a, int b, int c, int d);
    t0 = a; tLo = b; tMi = c; tHi = d;
    thrL0 = 18'(a); thrL1Low = 18'(b); thrL1Mid = 18'(c); thrL1High = 18'(d);
  endtask

  // expected decisions for peak candidate j, registered at edge e
  task automatic checkDecision(int j, int e);
    bit eL0, eLo, eMi, eHi, lo, mi, hi;
    int selW, t;
    logic [2:0] selM;
    eL0 = 0; eLo = 0; eMi = 0; eHi = 0; selW = -1; selM = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (peakAt(j, w)) begin
        t = tAt(j, w);
        lo = t > tLo; mi = t > tMi; hi = t > tHi;
        eL0 = 1; eLo |= lo; eMi |= mi; eHi |= hi;
        if (selW < 0 && (lo | mi | hi)) begin selW = w; selM = {hi, mi, lo}; end
      end
    end
    chk("R2 R3 R4 R5 R6 l0Trig", 32'(l0Trig), 32'(eL0));
    chk("R7 R8 l1Low", 32'(l1Low), 32'(eLo));
    chk("R7 R8 l1Mid", 32'(l1Mid), 32'(eMi));
    chk("R7 R8 l1High", 32'(l1High), 32'(eHi));
    if (selW >= 0) begin
      mdl[wp] = {e[15:0], selM, selW[5:0]};
      wp = (wp + 1) % HD;
    end
  endtask

  // called at a falling edge: check last decision, apply next sample set
  task automatic step();
    checkDecision(n - 4, edgeNo - 1);
    for (int w = 0; w < NWIN; w++) spH[n][w] = winSumOf(w);
    sampleGrid = grid;
    @(posedge clk); @(negedge clk);
    n++; edgeNo++;
  endtask

  task automatic setCell(int r, int c, int v);
    grid[(r * COLS + c) * SW +: SW] = SW'(v);
  endtask

  task automatic flush(int k);
    grid = '0;
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < HD; a++) begin
      rdAddr = 4'(a);
      @(posedge clk); @(negedge clk);
      edgeNo++;
      chk(tag, 32'(rdData), 32'(mdl[a]));
    end
  endtask

  // pulse of up to four samples on one cell, then a flush
  task automatic pulse(int r, int c, int a0, int a1, int a2, int a3);
    int amp [4];
    amp[0] = a0; amp[1] = a1; amp[2] = a2; amp[3] = a3;
    for (int i = 0; i < 4; i++) begin grid = '0; setCell(r, c, amp[i]); step(); end
    flush(7);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < HD; i++) mdl[i] = '0;
    setThr(2000, 4000, 8000, 16000);
    grid = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 l0Trig reset", 32'(l0Trig), 0);
    chk("R1 l1 reset", 32'({l1Low, l1Mid, l1High}), 0);
    chk("R1 rdData reset", 32'(rdData), 0);
    readAll("R1 R11 cleared store");

    // R4: flat top 6000,6000 -> peak on the second value, low only
    pulse(2, 5, 1000, 3000, 2000, 0);
    // R2: corner windows 0 and 54, all three grades
    pulse(0, 0, 4095, 4095, 4095, 4095);
    pulse(7, 13, 4095, 4095, 4095, 4095);
    // R5: sum equal to the threshold does not fire, one below does
    setThr(500, 100, 8000, 16000);
    pulse(3, 3, 500, 0, 0, 0);
    setThr(499, 100, 8000, 16000);
    pulse(3, 3, 500, 0, 0, 0);
    // R8: second-level threshold below first level, sum between them
    setThr(2000, 100, 200, 300);
    pulse(4, 8, 1000, 0, 0, 0);
    setThr(2000, 4000, 8000, 16000);
    readAll("R9 R10 R11 directed entries");

    // random phase: noise plus sparse multi-sample pulses
    for (int it = 0; it < 60; it++) begin
      int r = $urandom % ROWS, c = $urandom % COLS, len = 1 + $urandom % 4;
      int amp = $urandom % 4096, gap = $urandom % 4;
      for (int s = 0; s < len + gap; s++) begin
        grid = '0;
        for (int q = 0; q < ROWS * COLS; q++) grid[q * SW +: SW] = SW'($urandom % 4);
        if (s < len) setCell(r, c, amp);
        if ((it % 5) == 0 && s < len) setCell((r + 2) % ROWS, (c + 3) % COLS, amp / 2);
        step();
      end
    end
    flush(7);
    readAll("R9 R10 R11 wrapped entries");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule